// File: doc/BRIEF.md
# Buffered ADC Trigger Comparator

This block turns the count of a triangle-wave (up/down) PWM carrier into start requests for an analog-to-digital converter. Two trigger channels, A and B, each compare the carrier count against their own active trigger point. A one-clock pulse is raised when the count reaches that point in a counting direction that software has enabled for the channel.

Software never writes an active trigger point directly. It writes a per-channel staging register. The staged value is copied into the active register only at a crest event, a trough event, both, or never, as chosen by a 2-bit field. A new trigger point therefore cannot take effect in the middle of a carrier period. A channel can also be tied to the interrupt-skipping scheme of the surrounding timer. When it is tied, the channel only fires in carrier periods whose compare interrupt or overflow/underflow interrupt is not being skipped.

The carrier counter, the skipping counter, the PWM outputs and the converter are outside this block. It receives the count, the direction, single-cycle crest and trough pulses, two "period not skipped" flags and a simple register write port.

Top module: `adc_trig_cmp`

## Requirements
- R1: After reset, the control register, both staging registers and both active trigger points are zero, every enable is off, and neither trigger output is high.
- R2: The write port decodes `wr_addr` as follows: 0 is control, 1 is the channel A staging register and 2 is the channel B staging register. A staging write does not change the active trigger point it feeds.
- R3: Control bits [1:0] select the copy moment from staging to active registers for both channels: 00 never, 01 on `crest_pulse`, 10 on `trough_pulse`, 11 on either pulse.
- R4: A staging write in the same cycle as a selected copy event is the value copied.
- R5: A trigger output is high for exactly the cycle after a cycle in which all of the following hold: `cnt_val` equals the channel's active point, the direction is enabled, and the skip gate is open. `cnt_up` is 1 while counting up.
- R6: Each channel has its own direction enables. Control bit 2 enables up-counting for A, bit 3 enables down-counting for A, bit 4 enables up-counting for B and bit 5 enables down-counting for B. A match in a disabled direction gives no pulse.
- R7: A qualifying match held over consecutive cycles gives a single pulse, not one per cycle.
- R8: Control bits 6 and 7 tie channel A to `skip_cmp_ok` and to `skip_ovf_ok`. Bits 8 and 9 do the same for channel B. A tied channel fires only while every flag it is tied to is 1.
- R9: The two channels are independent. A match, a setting or a staging value of one channel never causes or blocks a pulse on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 16 | Carrier counter value |
| cnt_up | input | 1 | 1 while the carrier counts up, 0 while it counts down |
| crest_pulse | input | 1 | Single-cycle pulse at the carrier crest |
| trough_pulse | input | 1 | Single-cycle pulse at the carrier trough |
| skip_cmp_ok | input | 1 | 1 in periods whose compare interrupt is not skipped |
| skip_ovf_ok | input | 1 | 1 in periods whose overflow/underflow interrupt is not skipped |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 staging A, 2 staging B |
| wr_data | input | 16 | Write data |
| trig_a | output | 1 | Channel A start-request pulse |
| trig_b | output | 1 | Channel B start-request pulse |

## Verification
An active trigger point that is copied at the wrong moment shows up as a pulse at the old count, or a missing pulse at the new one, in the first carrier pass after the event. The bench therefore probes the count that was just staged and the count that was previously active right after each crest and trough. A stale match-history bit shows up either as a second pulse on the next cycle of a held match or as a lost pulse on the next fresh match. A wrong direction or skip gate shows up as a pulse on the very cycle after a match that should have been blocked, or the lack of one.

// File: rtl/adc_trig_pkg.sv
// Package: shared constants and types of the buffered ADC trigger comparator.
// Assumes two channels; the control layout below is decoded by adc_trig_regs.
package adc_trig_pkg;

    localparam int NUM_CH   = 2;
    localparam int ADDR_W   = 2;
    localparam int CTRL_W   = 10;

    // Register select codes on the write port.
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STG_A = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STG_B = 2'd2;

    // Control bit positions.
    localparam int MODE_LSB     = 0;
    localparam int DIR_EN_LSB   = 2;   // two bits per channel: up, down
    localparam int LINK_LSB     = 6;   // two bits per channel: cmp, ovf

    // Copy moment from staging to active trigger point.
    typedef enum logic [1:0] {
        XFER_NONE   = 2'b00,
        XFER_CREST  = 2'b01,
        XFER_TROUGH = 2'b10,
        XFER_BOTH   = 2'b11
    } xfer_mode_e;

    // Per-channel qualification settings.
    typedef struct packed {
        logic link_ovf;
        logic link_cmp;
        logic en_dn;
        logic en_up;
    } ch_cfg_t;

    // Staging register address of a channel.
    function automatic logic [ADDR_W-1:0] stg_addr(input int ch);
        return (ch == 0) ? ADDR_STG_A : ADDR_STG_B;
    endfunction

endpackage

// File: rtl/adc_trig_regs.sv
// Module: adc_trig_regs
// Holds the control register and the per-channel staging registers written
// through the simple write port. Also presents, per channel, the value a copy
// event in this cycle must take (the incoming write if one targets it).
// Assumes wr_data is at least CTRL_W bits wide.
module adc_trig_regs
    import adc_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CNT_W-1:0]             wr_data,
    output xfer_mode_e                   xfer_mode,
    output ch_cfg_t [NUM_CH-1:0]         ch_cfg,
    output logic [NUM_CH-1:0][CNT_W-1:0] stg_next
);

    logic [CTRL_W-1:0]            ctrl_q;
    logic [NUM_CH-1:0][CNT_W-1:0] stg_q;
    logic                         ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

    // Control register: capture the low control bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wr_data[CTRL_W-1:0];
        end
    end

    assign xfer_mode = xfer_mode_e'(ctrl_q[MODE_LSB +: 2]);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_stg
            logic stg_wr;
            assign stg_wr = wr_en && (wr_addr == stg_addr(c));

            // Staging register of channel c: loaded by software only.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_q[c] <= '0;
                end else if (stg_wr) begin
                    stg_q[c] <= wr_data;
                end
            end

            // Value a copy event this cycle takes: a same-cycle write wins.
            always_comb begin
                stg_next[c] = stg_wr ? wr_data : stg_q[c];
            end

            // Decode the channel's qualification fields.
            always_comb begin
                ch_cfg[c].en_up    = ctrl_q[DIR_EN_LSB + 2*c];
                ch_cfg[c].en_dn    = ctrl_q[DIR_EN_LSB + 2*c + 1];
                ch_cfg[c].link_cmp = ctrl_q[LINK_LSB + 2*c];
                ch_cfg[c].link_ovf = ctrl_q[LINK_LSB + 2*c + 1];
            end

            // R2
            ctrl_keeps_stg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr != stg_addr(c)) |=> $stable(stg_q[c]));
        end
    endgenerate

    // R2
    stg_wr_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/adc_trig_xfer.sv
// Module: adc_trig_xfer
// Active trigger point of one channel. Copies the staged value when the
// selected crest/trough event arrives; holds it otherwise.
// Assumes crest_pulse and trough_pulse are single-cycle pulses.
module adc_trig_xfer
    import adc_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xfer_mode_e       xfer_mode,
    input  logic             crest_pulse,
    input  logic             trough_pulse,
    input  logic [CNT_W-1:0] stg_next,
    output logic [CNT_W-1:0] active_pt
);

    logic copy_evt;

    // Select the copy event from the mode field.
    always_comb begin
        unique case (xfer_mode)
            XFER_CREST:  copy_evt = crest_pulse;
            XFER_TROUGH: copy_evt = trough_pulse;
            XFER_BOTH:   copy_evt = crest_pulse || trough_pulse;
            default:     copy_evt = 1'b0;
        endcase
    end

    // Active trigger point register: updated only on a copy event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_pt <= '0;
        end else if (copy_evt) begin
            active_pt <= stg_next;
        end
    end

    // R3
    hold_without_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!crest_pulse && !trough_pulse) |=> $stable(active_pt));

    // R3
    mode_none_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_mode == XFER_NONE) |=> $stable(active_pt));

endmodule

// File: rtl/adc_trig_chan.sv
// Module: adc_trig_chan
// Compare and qualification of one trigger channel. A qualified match is a
// count equal to the active point in an enabled direction with the skip gate
// open; the output pulses one cycle after the first cycle of such a match.
// Assumes the skip flags are stable for a carrier period.
module adc_trig_chan
    import adc_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_up,
    input  logic [CNT_W-1:0] active_pt,
    input  ch_cfg_t          cfg,
    input  logic             skip_cmp_ok,
    input  logic             skip_ovf_ok,
    output logic             trig
);

    logic eq_hit;
    logic dir_ok;
    logic gate_ok;
    logic qual_hit;
    logic hit_prev;

    // Combine compare, direction enable and skip gate.
    always_comb begin
        eq_hit   = (cnt_val == active_pt);
        dir_ok   = cnt_up ? cfg.en_up : cfg.en_dn;
        gate_ok  = (!cfg.link_cmp || skip_cmp_ok) && (!cfg.link_ovf || skip_ovf_ok);
        qual_hit = eq_hit && dir_ok && gate_ok;
    end

    // Pulse register and match history for single-pulse behaviour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig     <= 1'b0;
            hit_prev <= 1'b0;
        end else begin
            trig     <= qual_hit && !hit_prev;
            hit_prev <= qual_hit;
        end
    end

    // R7
    one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    // R5
    match_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past(cnt_val == active_pt));

    // R6
    dir_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past(cnt_up ? cfg.en_up : cfg.en_dn));

    // R8
    skip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past((!cfg.link_cmp || skip_cmp_ok) && (!cfg.link_ovf || skip_ovf_ok)));

endmodule

// File: rtl/adc_trig_cmp.sv
// Module: adc_trig_cmp (top)
// Buffered two-channel ADC trigger comparator for an up/down PWM carrier.
// Instantiates the register file, then per channel an active trigger point
// with crest/trough copy and a compare/qualify stage.
// Assumes the carrier counter, crest/trough pulses and skip flags come from
// the surrounding timer on the same clock.
module adc_trig_cmp
    import adc_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_up,
    input  logic              crest_pulse,
    input  logic              trough_pulse,
    input  logic              skip_cmp_ok,
    input  logic              skip_ovf_ok,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              trig_a,
    output logic              trig_b
);

    xfer_mode_e                   xfer_mode;
    ch_cfg_t [NUM_CH-1:0]         ch_cfg;
    logic [NUM_CH-1:0][CNT_W-1:0] stg_next;
    logic [NUM_CH-1:0][CNT_W-1:0] active_pt;
    logic [NUM_CH-1:0]            trig_vec;

    adc_trig_regs #(.CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .xfer_mode (xfer_mode),
        .ch_cfg    (ch_cfg),
        .stg_next  (stg_next)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            adc_trig_xfer #(.CNT_W(CNT_W)) xfer_i (
                .clk          (clk),
                .rst_n        (rst_n),
                .xfer_mode    (xfer_mode),
                .crest_pulse  (crest_pulse),
                .trough_pulse (trough_pulse),
                .stg_next     (stg_next[c]),
                .active_pt    (active_pt[c])
            );

            adc_trig_chan #(.CNT_W(CNT_W)) chan_i (
                .clk         (clk),
                .rst_n       (rst_n),
                .cnt_val     (cnt_val),
                .cnt_up      (cnt_up),
                .active_pt   (active_pt[c]),
                .cfg         (ch_cfg[c]),
                .skip_cmp_ok (skip_cmp_ok),
                .skip_ovf_ok (skip_ovf_ok),
                .trig        (trig_vec[c])
            );
        end
    endgenerate

    assign trig_a = trig_vec[0];
    assign trig_b = trig_vec[1];

endmodule

// File: tb/adc_trig_cmp_tb_top.sv
// Bench: a vector table walked once, then directed reset checks.
module adc_trig_cmp_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt_val;
    logic        cnt_up;
    logic        crest_pulse;
    logic        trough_pulse;
    logic        skip_cmp_ok;
    logic        skip_ovf_ok;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        trig_a;
    logic        trig_b;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_trig_cmp dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_val      (cnt_val),
        .cnt_up       (cnt_up),
        .crest_pulse  (crest_pulse),
        .trough_pulse (trough_pulse),
        .skip_cmp_ok  (skip_cmp_ok),
        .skip_ovf_ok  (skip_ovf_ok),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .trig_a       (trig_a),
        .trig_b       (trig_b)
    );

    // One step: inputs of a cycle and the trigger pair expected after its edge.
    typedef struct packed {
        logic        we;
        logic [1:0]  ad;
        logic [15:0] wd;
        logic [15:0] cnt;
        logic        up;
        logic        cr;
        logic        tr;
        logic        oc;
        logic        oo;
        logic        ea;
        logic        eb;
    } step_t;

    localparam int NSTEP = 37;
    // ctrl 0x01E: trough copy, A up+down, B up. 0x01D: crest copy.
    // 0x01C: no copy. 0x25F: both, A tied to cmp flag, B tied to ovf flag.
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 2'd0, 16'h001E, 16'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 1 R6 setup
        '{1'b1, 2'd1, 16'd10,   16'd6,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 2
        '{1'b1, 2'd2, 16'd20,   16'd10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 3 R2 staged only
        '{1'b0, 2'd0, 16'd0,    16'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 4 R2
        '{1'b0, 2'd0, 16'd0,    16'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // 5 R6 A down, B down off
        '{1'b0, 2'd0, 16'd0,    16'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // 6 R7 A held, R9 B fires
        '{1'b0, 2'd0, 16'd0,    16'd1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 7
        '{1'b0, 2'd0, 16'd0,    16'd10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // 8 R3 trough copy A
        '{1'b0, 2'd0, 16'd0,    16'd20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // 9 R3 trough copy B
        '{1'b0, 2'd0, 16'd0,    16'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 10 R6 B down off
        '{1'b0, 2'd0, 16'd0,    16'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // 11 R5
        '{1'b1, 2'd1, 16'd30,   16'd5,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 12 R3 crest ignored
        '{1'b0, 2'd0, 16'd0,    16'd10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // 13 R3 old point kept
        '{1'b1, 2'd0, 16'h001D, 16'd11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 14
        '{1'b1, 2'd2, 16'd40,   16'd12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 15 R4 same-cycle write
        '{1'b0, 2'd0, 16'd0,    16'd30, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // 16 R3 crest copy A
        '{1'b0, 2'd0, 16'd0,    16'd40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 17 R6
        '{1'b0, 2'd0, 16'd0,    16'd40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // 18 R4 B got 40
        '{1'b1, 2'd0, 16'h001C, 16'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 19
        '{1'b1, 2'd1, 16'd50,   16'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 20
        '{1'b0, 2'd0, 16'd0,    16'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 21
        '{1'b0, 2'd0, 16'd0,    16'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // 22
        '{1'b0, 2'd0, 16'd0,    16'd30, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // 23 R3 mode 00 keeps 30
        '{1'b0, 2'd0, 16'd0,    16'd50, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 24 R3
        '{1'b1, 2'd0, 16'h025F, 16'd1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 25 R8 setup
        '{1'b0, 2'd0, 16'd0,    16'd30, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // 26 R8 A blocked
        '{1'b0, 2'd0, 16'd0,    16'd31, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 27
        '{1'b0, 2'd0, 16'd0,    16'd30, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // 28 R8 A open
        '{1'b0, 2'd0, 16'd0,    16'd40, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // 29 R8 B blocked
        '{1'b0, 2'd0, 16'd0,    16'd41, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 30
        '{1'b0, 2'd0, 16'd0,    16'd40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // 31 R8 B open
        '{1'b1, 2'd1, 16'd7,    16'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 32
        '{1'b0, 2'd0, 16'd0,    16'd2,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 33 both: crest
        '{1'b0, 2'd0, 16'd0,    16'd7,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // 34 R3
        '{1'b1, 2'd1, 16'd9,    16'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // 35
        '{1'b0, 2'd0, 16'd0,    16'd1,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // 36 both: trough
        '{1'b0, 2'd0, 16'd0,    16'd9,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}  // 37 R3
    };

    task automatic check(input string req, input logic act_a, input logic act_b,
                         input logic exp_a, input logic exp_b);
        checks++;
        if (act_a !== exp_a || act_b !== exp_b) begin
            failures++;
            $display("FAIL %s: trig_a/trig_b actual %b%b expected %b%b at %0t",
                     req, act_a, act_b, exp_a, exp_b, $time);
        end
    endtask

    task automatic drive(input step_t s);
        @(negedge clk);
        wr_en        = s.we;
        wr_addr      = s.ad;
        wr_data      = s.wd;
        cnt_val      = s.cnt;
        cnt_up       = s.up;
        crest_pulse  = s.cr;
        trough_pulse = s.tr;
        skip_cmp_ok  = s.oc;
        skip_ovf_ok  = s.oo;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; cnt_val = 16'd100; cnt_up = 1'b1;
        crest_pulse = 1'b0; trough_pulse = 1'b0; skip_cmp_ok = 1'b0; skip_ovf_ok = 1'b0;
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs low during reset
        check("R1", trig_a, trig_b, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NSTEP; i++) begin
            drive(STEPS[i]);
            check($sformatf("step%0d", i + 1), trig_a, trig_b, STEPS[i].ea, STEPS[i].eb);
        end

        // R1: reset clears control and active points (A was 9).
        drive('{1'b0, 2'd0, 16'd0, 16'd9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1", trig_a, trig_b, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: enables off after reset, so a zero count gives nothing.
        drive('{1'b0, 2'd0, 16'd0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});
        check("R1", trig_a, trig_b, 1'b0, 1'b0);
        // R1: with A up enabled, the count 0 matches the cleared active point.
        drive('{1'b1, 2'd0, 16'h0004, 16'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        check("R1", trig_a, trig_b, 1'b0, 1'b0);
        drive('{1'b0, 2'd0, 16'd0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});
        check("R1", trig_a, trig_b, 1'b1, 1'b0);
        // R7: match held three cycles gives no further pulse.
        drive('{1'b0, 2'd0, 16'd0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        check("R7", trig_a, trig_b, 1'b0, 1'b0);
        drive('{1'b0, 2'd0, 16'd0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        check("R7", trig_a, trig_b, 1'b0, 1'b0);
        // R9: B stays silent on a matching count with its enables off.
        drive('{1'b0, 2'd0, 16'd0, 16'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        check("R9", trig_a, trig_b, 1'b0, 1'b0);
        drive('{1'b0, 2'd0, 16'd0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});
        check("R9", trig_a, trig_b, 1'b1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule